// File: doc/BRIEF.md
# Serial configuration PROM sequencer

This block is the read side of a configuration memory that streams a bitstream into an FPGA. It is clocked by the configuration clock that the FPGA generates. An internal address counter and bit counter walk through a stored array and present the data one bit per clock (serial mode) or one whole byte per clock (byte mode). The stored array is filled through a simple synchronous write port.

A level-sensitive reset/output-enable input rewinds the walk to address zero, so every configuration starts at the first stored program. If that input is never asserted, the counters keep their position, and the next enabled period resumes where the previous one stopped. This allows several programs to be stored back to back. When the last stored slot has been delivered, the block stops driving data and lowers its cascade-enable output, which hands the stream to the next device in a chain. A separate config-request input produces a timed low pulse on a restart output, meant for the FPGA's program input.

The data output is modelled as data plus a drive-enable flag. A disabled output reads as all zeros.

Top module: `cfgp_seq`

## Requirements
- R1: While `pwr_rst_n` is low, the address and bit counters are held at zero. In that state `cas_en_n` is 1, `restart_n` is 1, and the data output is not driven (`dout_oe` is 0, `dout` is 0).
- R2: In serial mode (`byte_mode` = 0), `dout[0]` carries bit (7 − b) of the stored byte at the current address a, so each byte goes out MSB first, and `dout[7:1]` is 0. Each enabled rising edge increments b. When b is 7, the edge sets b to 0 and increments a.
- R3: In byte mode (`byte_mode` = 1), `dout` equals the whole stored byte at the current address. The first byte is valid as soon as the block is enabled, before the first clock edge. Each enabled edge then increments the address and clears the bit counter, including when byte mode is entered partway through a byte.
- R4: While `ce_n` is 1, `dout_oe` is 0, `dout` is 0, and clock edges leave both counters unchanged.
- R5: The reset/output-enable input `rst_oe` is active high with the default `RST_ACT_HIGH` = 1 (active low when 0). While it is asserted, `dout_oe` is 0. The next clock edge clears both counters and returns `cas_en_n` to 1.
- R6: If `rst_oe` is not asserted, disabling and then re-enabling through `ce_n` resumes the stream at exactly the next undelivered bit or byte.
- R7: The edge that consumes the last slot of address `LAST_ADDR` (bit 7 in serial mode, or the byte itself in byte mode) drives `cas_en_n` low. It stays low until a reset. While it is low, `dout_oe` is 0 and the counters do not move. `cas_en_n` is 1 at every earlier position.
- R8: A rising edge on `cfg_req` while no pulse is running drives `restart_n` low from the next clock edge. It stays low for exactly PULSE_CYC = round(`PULSE_NS`/`CLK_NS`) cycles: 20 cycles, or 400 ns, with the defaults. Request edges during a pulse do not extend it, and a request held high does not start a second pulse.
- R9: When `wr_en` is 1 at a clock edge, `wr_data` is stored at `wr_addr`. Later reads at that address return the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; rising edges step the stream |
| pwr_rst_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_oe | input | 1 | Reset/output-enable; polarity set by RST_ACT_HIGH |
| ce_n | input | 1 | Chip enable, active low |
| byte_mode | input | 1 | 0 = one bit per clock, 1 = one byte per clock |
| wr_en | input | 1 | Store write strobe |
| wr_addr | input | ADDR_W | Store write address |
| wr_data | input | 8 | Store write byte |
| cfg_req | input | 1 | Configuration restart request (edge triggered) |
| dout | output | 8 | Stream data (bit 0 only in serial mode), zero when not driven |
| dout_oe | output | 1 | Data drive enable |
| cas_en_n | output | 1 | Cascade enable for the next device, active low |
| restart_n | output | 1 | Timed restart pulse, active low |

## Verification
The checker watches several rules on every cycle:
- counter stepping in both modes, including the wrap from bit 7;
- counters frozen while chip enable is off;
- the effect of reset on the counters;
- a sticky cascade output, with no data driven once it is low;
- zero data whenever the drive is off;
- the exact restart pulse width.

Some rules can only be shown by the bench's scenarios against an independent model of the stored bytes:
- the data values themselves, MSB-first order, and first-byte availability before any edge;
- correct resumption after a pause;
- the exact position at which the cascade hand-off occurs;
- the fact that request edges during a pulse are ignored.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  typedef enum logic {
    MODE_SERIAL = 1'b0,
    MODE_BYTE   = 1'b1
  } stream_mode_e;

  // Restart pulse length in clock cycles, rounded to the nearest cycle.
  function automatic int unsigned pulse_cycles(input int unsigned clk_ns,
                                               input int unsigned pulse_ns);
    return (pulse_ns + clk_ns / 2) / clk_ns;
  endfunction

  // Bit lane of a stored byte sent at bit position b (MSB first).
  function automatic logic [2:0] lane_of(input logic [2:0] b);
    return 3'd7 - b;
  endfunction

endpackage

// File: rtl/cfgp_store.sv
module cfgp_store #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [2:0]        rd_bit,
  input  logic              byte_mode,
  output logic [7:0]        rd_word
);
  import cfgp_pkg::*;

  logic [7:0] mem [DEPTH];
  logic [7:0] cur_byte;
  logic       cur_serial;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign cur_byte   = mem[rd_addr];
  assign cur_serial = cur_byte[lane_of(rd_bit)];
  assign rd_word    = (stream_mode_e'(byte_mode) == MODE_BYTE) ? cur_byte
                                                               : {7'b0, cur_serial};
endmodule

// File: rtl/cfgp_walker.sv
module cfgp_walker #(
  parameter int ADDR_W    = 5,
  parameter int LAST_ADDR = 19
) (
  input  logic              clk,
  input  logic              pwr_rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic              byte_mode,
  output logic [ADDR_W-1:0] addr,
  output logic [2:0]        bitp,
  output logic              exhausted,
  output logic              step,
  output logic              wrap_evt,
  output logic              exhaust_evt
);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);

  logic at_final;

  // True when the current position is the last slot this device holds.
  function automatic logic final_slot(input logic [ADDR_W-1:0] a,
                                      input logic [2:0]        b,
                                      input logic              bm);
    return (a == LAST_A) && (bm || (b == 3'd7));
  endfunction

  assign step        = run & ~clr & ~exhausted;
  assign at_final    = final_slot(addr, bitp, byte_mode);
  assign exhaust_evt = step & at_final;
  assign wrap_evt    = step & ~byte_mode & (bitp == 3'd7);

  always_ff @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) begin
      addr      <= '0;
      bitp      <= '0;
      exhausted <= 1'b0;
    end else if (clr) begin
      addr      <= '0;
      bitp      <= '0;
      exhausted <= 1'b0;
    end else if (exhaust_evt) begin
      exhausted <= 1'b1;
    end else if (step) begin
      if (byte_mode || (bitp == 3'd7)) begin
        addr <= addr + 1'b1;
        bitp <= '0;
      end else begin
        bitp <= bitp + 3'd1;
      end
    end
  end
endmodule

// File: rtl/cfgp_restart.sv
module cfgp_restart #(
  parameter int PULSE_CYC = 20
) (
  input  logic clk,
  input  logic pwr_rst_n,
  input  logic req,
  output logic restart_n
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic             req_q;
  logic             fire;

  assign fire      = req & ~req_q & (cnt == '0);
  assign restart_n = (cnt == '0);

  always_ff @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) begin
      cnt   <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= req;
      if (fire)            cnt <= CNT_W'(PULSE_CYC);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/cfgp_seq.sv
module cfgp_seq #(
  parameter int DEPTH        = 32,
  parameter int LAST_ADDR    = 19,
  parameter bit RST_ACT_HIGH = 1'b1,
  parameter int CLK_NS       = 20,
  parameter int PULSE_NS     = 400,
  localparam int ADDR_W      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              pwr_rst_n,
  input  logic              rst_oe,
  input  logic              ce_n,
  input  logic              byte_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              cfg_req,
  output logic [7:0]        dout,
  output logic              dout_oe,
  output logic              cas_en_n,
  output logic              restart_n
);
  localparam int PULSE_CYC = int'(cfgp_pkg::pulse_cycles(CLK_NS, PULSE_NS));

  logic              rst_act;
  logic [ADDR_W-1:0] cur_addr;
  logic [2:0]        cur_bit;
  logic              exhausted;
  logic              step;
  logic              wrap_evt;
  logic              exhaust_evt;
  logic [7:0]        rd_word;

  generate
    if (RST_ACT_HIGH) begin : g_rst_hi
      assign rst_act = rst_oe;
    end else begin : g_rst_lo
      assign rst_act = ~rst_oe;
    end
  endgenerate

  cfgp_walker #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_walker (
    .clk        (clk),
    .pwr_rst_n  (pwr_rst_n),
    .clr        (rst_act),
    .run        (~ce_n),
    .byte_mode  (byte_mode),
    .addr       (cur_addr),
    .bitp       (cur_bit),
    .exhausted  (exhausted),
    .step       (step),
    .wrap_evt   (wrap_evt),
    .exhaust_evt(exhaust_evt)
  );

  cfgp_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (cur_addr),
    .rd_bit   (cur_bit),
    .byte_mode(byte_mode),
    .rd_word  (rd_word)
  );

  cfgp_restart #(.PULSE_CYC(PULSE_CYC)) u_restart (
    .clk      (clk),
    .pwr_rst_n(pwr_rst_n),
    .req      (cfg_req),
    .restart_n(restart_n)
  );

  assign dout_oe  = pwr_rst_n & ~ce_n & ~rst_act & ~exhausted;
  assign dout     = dout_oe ? rd_word : 8'h00;
  assign cas_en_n = ~exhausted;
endmodule

// File: rtl/cfgp_seq_chk.sv
module cfgp_seq_chk #(
  parameter int ADDR_W    = 5,
  parameter int PULSE_CYC = 20
) (
  input logic              clk,
  input logic              pwr_rst_n,
  input logic              rst_act,
  input logic              ce_n,
  input logic              byte_mode,
  input logic              cfg_req,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [2:0]        cur_bit,
  input logic              step,
  input logic              wrap_evt,
  input logic              exhaust_evt,
  input logic [7:0]        dout,
  input logic              dout_oe,
  input logic              cas_en_n,
  input logic              restart_n
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n)    low_cnt <= '0;
    else if (!restart_n) low_cnt <= low_cnt + 16'd1;
    else               low_cnt <= '0;
  end

  p_serial_step_r2: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (step && !byte_mode && cur_bit != 3'd7)
      |=> (cur_bit == $past(cur_bit) + 3'd1) && $stable(cur_addr));

  p_wrap_r2: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (wrap_evt && !exhaust_evt)
      |=> (cur_bit == 3'd0) && (cur_addr == $past(cur_addr) + 1'b1));

  p_byte_step_r3: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (step && byte_mode && !exhaust_evt)
      |=> (cur_bit == 3'd0) && (cur_addr == $past(cur_addr) + 1'b1));

  p_hold_off_r4: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (ce_n && !rst_act) |=> $stable(cur_addr) && $stable(cur_bit));

  p_quiet_r4: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    !dout_oe |-> (dout == 8'h00));

  p_rst_off_r5: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    rst_act |-> !dout_oe);

  p_rst_clear_r5: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    rst_act |=> (cur_addr == '0) && (cur_bit == 3'd0) && cas_en_n);

  p_cas_sticky_r7: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (!cas_en_n && !rst_act) |=> !cas_en_n && $stable(cur_addr) && $stable(cur_bit));

  p_cas_quiet_r7: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    !cas_en_n |-> !dout_oe);

  p_pulse_start_r8: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    ($rose(cfg_req) && restart_n) |=> !restart_n);

  p_pulse_len_r8: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (restart_n && low_cnt != 16'd0) |-> (low_cnt == 16'(PULSE_CYC)));
endmodule

bind cfgp_seq cfgp_seq_chk #(.ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk        (clk),
  .pwr_rst_n  (pwr_rst_n),
  .rst_act    (rst_act),
  .ce_n       (ce_n),
  .byte_mode  (byte_mode),
  .cfg_req    (cfg_req),
  .cur_addr   (cur_addr),
  .cur_bit    (cur_bit),
  .step       (step),
  .wrap_evt   (wrap_evt),
  .exhaust_evt(exhaust_evt),
  .dout       (dout),
  .dout_oe    (dout_oe),
  .cas_en_n   (cas_en_n),
  .restart_n  (restart_n)
);

// File: tb/test_cfgp_seq.sv
module test_cfgp_seq;
  localparam int DEPTH  = 32;
  localparam int LAST   = 19;
  localparam int AW     = 5;
  localparam int PULSE  = 20;

  logic          clk = 1'b0;
  logic          pwr_rst_n, rst_oe, ce_n, byte_mode, wr_en, cfg_req;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [7:0]    dout;
  logic          dout_oe, cas_en_n, restart_n;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic [7:0] bm [DEPTH];
  int  ea, eb;
  bit  eexh;

  always #10 clk = ~clk;

  cfgp_seq i_cfgp_seq (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .rst_oe(rst_oe), .ce_n(ce_n),
    .byte_mode(byte_mode), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_req(cfg_req), .dout(dout), .dout_oe(dout_oe), .cas_en_n(cas_en_n),
    .restart_n(restart_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 29 + 7) ^ 8'hA5);
  endfunction

  function automatic logic [7:0] exp_word(input bit bym);
    if (bym) return bm[ea];
    return {7'b0, bm[ea][7 - eb]};
  endfunction

  task automatic model_step(input bit bym);
    if (bym || eb == 7) begin
      if (ea == LAST) eexh = 1'b1;
      else begin ea++; eb = 0; end
    end else eb++;
  endtask

  task automatic do_clear();
    rst_oe = 1'b1;
    ce_n   = 1'b1;
    cyc();
    rst_oe = 1'b0;
    ea = 0; eb = 0; eexh = 1'b0;
  endtask

  task automatic run(input int n, input bit bym, input string req);
    byte_mode = bym;
    ce_n      = 1'b0;
    #1;
    for (int k = 0; k < n; k++) begin
      chk({req, " oe"},   dout_oe,  1'b1);
      chk({req, " data"}, dout,     exp_word(bym));
      chk("R7 cas idle", cas_en_n, 1'b1);
      cyc();
      model_step(bym);
    end
    ce_n = 1'b1;
  endtask

  task automatic t_reset();
    pwr_rst_n = 1'b0; rst_oe = 1'b0; ce_n = 1'b1; byte_mode = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; cfg_req = 1'b0;
    repeat (3) cyc();
    chk("R1 restart_n", restart_n, 1'b1);
    chk("R1 cas_en_n",  cas_en_n,  1'b1);
    chk("R1 dout_oe",   dout_oe,   1'b0);
    chk("R1 dout",      dout,      8'h00);
    pwr_rst_n = 1'b1;
    cyc();
    for (int i = 0; i < DEPTH; i++) begin
      bm[i] = pat(i);
      wr_en = 1'b1; wr_addr = AW'(i); wr_data = pat(i);
      cyc();
    end
    wr_en = 1'b0;
    ea = 0; eb = 0; eexh = 1'b0;
  endtask

  task automatic t_serial();
    run(20, 1'b0, "R2 serial");
    chk("R2 position addr", 32'(ea), 32'd2);
  endtask

  task automatic t_hold();
    ce_n = 1'b1;
    #1;
    chk("R4 oe off", dout_oe, 1'b0);
    chk("R4 dout zero", dout, 8'h00);
    repeat (4) cyc();
    byte_mode = 1'b0; ce_n = 1'b0;
    #1;
    chk("R6 resume serial", dout, exp_word(1'b0));
    ce_n = 1'b1;
    run(6, 1'b0, "R6 serial after pause");
  endtask

  task automatic t_clear();
    rst_oe = 1'b1; ce_n = 1'b0;
    #1;
    chk("R5 oe off in reset", dout_oe, 1'b0);
    cyc();
    rst_oe = 1'b0;
    ea = 0; eb = 0; eexh = 1'b0;
    #1;
    chk("R5 rewound", dout, {7'b0, bm[0][7]});
    ce_n = 1'b1;
  endtask

  task automatic t_express();
    run(3, 1'b0, "R2 serial prefix");
    byte_mode = 1'b1; ce_n = 1'b0;
    #1;
    chk("R3 mid-byte switch", dout, bm[0]);
    cyc();
    ea = 1; eb = 0;
    run(LAST, 1'b1, "R3 byte");
    chk("R7 cas after last byte", cas_en_n, 1'b0);
    ce_n = 1'b0;
    repeat (3) cyc();
    chk("R7 cas sticky", cas_en_n, 1'b0);
    chk("R7 oe off after last", dout_oe, 1'b0);
    ce_n = 1'b1;
    do_clear();
    #1;
    chk("R5 cas released", cas_en_n, 1'b1);
  endtask

  task automatic t_retain_byte();
    byte_mode = 1'b1; ce_n = 1'b0;
    #1;
    chk("R3 first byte before edge", dout, bm[0]);
    ce_n = 1'b1;
    run(5, 1'b1, "R3 byte run");
    repeat (3) cyc();
    byte_mode = 1'b1; ce_n = 1'b0;
    #1;
    chk("R6 resume byte", dout, bm[5]);
    ce_n = 1'b1;
  endtask

  task automatic t_serial_end();
    do_clear();
    run((LAST + 1) * 8, 1'b0, "R2 full serial");
    chk("R7 cas after last bit", cas_en_n, 1'b0);
    chk("R7 oe off", dout_oe, 1'b0);
    do_clear();
  endtask

  task automatic t_write();
    wr_en = 1'b1; wr_addr = '0; wr_data = 8'h3C; bm[0] = 8'h3C;
    cyc();
    wr_en = 1'b0;
    do_clear();
    byte_mode = 1'b1; ce_n = 1'b0;
    #1;
    chk("R9 rewritten byte", dout, 8'h3C);
    ce_n = 1'b1;
  endtask

  task automatic t_restart();
    int n;
    cfg_req = 1'b1;
    #1;
    chk("R8 not yet low", restart_n, 1'b1);
    cyc();
    n = 0;
    while (!restart_n && n < 100) begin
      n++;
      if (n == 5) cfg_req = 1'b0;
      if (n == 7) cfg_req = 1'b1;
      cyc();
    end
    chk("R8 pulse width", 32'(n), 32'(PULSE));
    repeat (3) cyc();
    chk("R8 no repeat on held req", restart_n, 1'b1);
    cfg_req = 1'b0;
    cyc();
  endtask

  initial begin
    t_reset();
    t_serial();
    t_hold();
    t_clear();
    t_express();
    t_retain_byte();
    t_serial_end();
    t_write();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule